// File: doc/BRIEF.md
# Display Link Training Sequencer

This block runs the two training phases of a multi-lane serial display link: clock recovery first, then channel equalisation. It programs the sink through a byte-register access port, drives the source transmitter through a drive port, polls the sink's six status bytes, and finally reports whether the link trained. A host pulses `start` with the sink's capabilities and the chosen lane count and rate code already on the inputs. The block then runs the whole sequence alone and raises `done` for one cycle, with `pass` holding the outcome.

Each lane's 4-bit status nibble and each lane's requested drive adjustment are decoded from the status bytes. The largest requested swing and the largest requested pre-emphasis over the active lanes become one drive setting that is shared by every lane. That setting is sent to the source and written to the sink. Timing is counted in clock cycles, scaled by the `CYC_PER_US` parameter. Both ports follow a simple handshake: the request stays high until an acknowledge.

Top module: `lt_seq`

## Requirements
- R1: After reset, and whenever idle, `busy`, `done`, `pass`, `reg_req` and `drv_req` are all 0.
- R2: Start-up first writes 0x01 to sink register 0x600, but only when `sink_rev` >= 0x11. It then writes register 0x107 with 0x10 when `spread_cap` is 1, or 0x00 when it is 0.
- R3: Start-up then writes register 0x101 with `lane_cnt`, setting bit 7 when `sink_rev` >= 0x11. Next it writes register 0x100 with `rate_code`, then writes 0x00 to the pattern register 0x102.
- R4: Clock recovery begins with a drive operation (pattern 1, level 0x00). It then writes 0x01 to register 0x102 and 0x00 to lane-set register 0x103, with `reg_len` = `lane_cnt`. A 400 µs settle follows, then the first poll wait.
- R5: Each poll wait is 100 µs in clock recovery and 400 µs in equalisation when `rd_interval` is 0, and `rd_interval` × 4 ms otherwise. Each poll is a read (`reg_rd`=1) of 6 bytes at address 0x202.
- R6: Lane n's status nibble is the low nibble (even n) or high nibble (odd n) of byte n>>1. Clock recovery passes when bit 0 is set for every lane below `lane_cnt`. Inactive lanes are ignored.
- R7: Lane n's request is in byte 4 + (n>>1), in the low nibble for even n and the high nibble for odd n, with swing in bits 1:0 and pre-emphasis in bits 3:2. The new level is {max-emph flag, pre-emphasis, max-swing flag, swing} in bits 5, 4:3, 2 and 1:0. Each part is the maximum over the active lanes, and each flag is set when its value is 3. The level goes to a drive operation and then to register 0x103.
- R8: Clock recovery fails when the current level has its max-swing flag set. It also fails on the poll where the swing has matched the previous poll's swing for the fifth consecutive time, which is the sixth poll at one swing.
- R9: Equalisation selects pattern 3 when `tps3_ok` is 1, and pattern 2 otherwise. It issues a drive operation with that pattern and writes the same value to 0x102, then waits one poll interval.
- R10: Equalisation passes when bit 0 of status byte 2 is set and every active lane's nibble has bits 2:0 all set.
- R11: Equalisation fails on the poll that follows six adjustments without passing, which is its seventh poll.
- R12: After a pass or a failure, the block waits 400 µs, writes 0x00 to 0x102, and issues a drive operation with pattern 0 and the level unchanged. It then pulses `done` for one cycle, with `pass` holding the result until the next start.
- R13: A poll answered with `reg_err`=1 ends the current phase as a failure at once, going straight to the finish step of R12.
- R14: A request holds its address and data until acknowledged, and the two ports never request at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin training |
| sink_rev | input | 8 | Sink revision byte |
| spread_cap | input | 1 | Sink supports downspread |
| tps3_ok | input | 1 | Pattern 3 usable for equalisation |
| lane_cnt | input | 3 | Active lanes: 1, 2 or 4 |
| rate_code | input | 8 | Link rate code written to the sink |
| rd_interval | input | 8 | Sink poll interval field |
| reg_req | output | 1 | Sink register access request |
| reg_rd | output | 1 | 1 = status read, 0 = write |
| reg_addr | output | 16 | Sink register address |
| reg_wdata | output | 8 | Write byte (replicated over `reg_len` bytes) |
| reg_len | output | 3 | Byte count of the access |
| reg_ack | input | 1 | Access completed |
| reg_err | input | 1 | Read failed (valid with `reg_ack`) |
| reg_rdata | input | 48 | Six status bytes, byte 0 in bits 7:0 |
| drv_req | output | 1 | Source drive update request |
| drv_pattern | output | 2 | Training pattern, 0 = off |
| drv_level | output | 8 | Shared lane drive level |
| drv_ack | input | 1 | Drive update applied |
| busy | output | 1 | Training sequence running |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Training result |

## Verification
The assertions assume that `sink_rev`, `lane_cnt`, `tps3_ok`, `spread_cap` and `rd_interval` stay constant while `busy` is high. They also assume that each acknowledge arrives only while its own request is raised. The bench drives the configuration only between runs, with the block idle. Its port responders raise an acknowledge for one cycle only while they see a matching request, and then drop it before answering the next one.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam logic [15:0] ADR_RATE     = 16'h0100;
    localparam logic [15:0] ADR_LANES    = 16'h0101;
    localparam logic [15:0] ADR_PATTERN  = 16'h0102;
    localparam logic [15:0] ADR_LANE_SET = 16'h0103;
    localparam logic [15:0] ADR_SPREAD   = 16'h0107;
    localparam logic [15:0] ADR_STATUS   = 16'h0202;
    localparam logic [15:0] ADR_POWER    = 16'h0600;

    localparam logic [7:0] POWER_D0     = 8'h01;
    localparam logic [7:0] SPREAD_HALF  = 8'h10;
    localparam logic [7:0] REV_NEW      = 8'h11;
    localparam logic [2:0] STATUS_BYTES = 3'd6;

    localparam int CR_REPEAT_MAX = 5;
    localparam int EQ_ADJUST_MAX = 5;

    typedef enum logic [4:0] {
        S_IDLE,
        S_POWER,
        S_SPREAD,
        S_LANES,
        S_RATE,
        S_PAT_OFF,
        S_PAT_SRC,
        S_PAT_SNK,
        S_LVL_DRV,
        S_LVL_SNK,
        S_SETTLE,
        S_WAIT,
        S_READ,
        S_EVAL,
        S_FIN_WAIT,
        S_FIN_SNK,
        S_FIN_SRC
    } lt_state_e;

endpackage

// File: rtl/lt_lane_status.sv
module lt_lane_status (
    input  logic       active,
    input  logic [2:0] stat_bits,
    input  logic [3:0] adj_nib,
    output logic       cr_ok,
    output logic       eq_ok,
    output logic [1:0] swing,
    output logic [1:0] emph
);

    always_comb begin
        cr_ok = !active || stat_bits[0];
        eq_ok = !active || (stat_bits == 3'b111);
        swing = active ? adj_nib[1:0] : 2'd0;
        emph  = active ? adj_nib[3:2] : 2'd0;
    end

endmodule

// File: rtl/lt_status_eval.sv
module lt_status_eval #(
    parameter int LANES  = 4,
    parameter int LCNT_W = 3
) (
    input  logic [LCNT_W-1:0]  lane_cnt,
    input  logic [4*LANES-1:0] lane_stat,
    input  logic [4*LANES-1:0] lane_adj,
    input  logic               align_ok,
    output logic               cr_all,
    output logic               eq_all,
    output logic [7:0]         level
);

    logic [LANES-1:0] cr_vec;
    logic [LANES-1:0] eq_vec;
    logic [1:0]       sw_vec [LANES];
    logic [1:0]       pe_vec [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lt_lane_status u_lane (
            .active    (LCNT_W'(g) < lane_cnt),
            .stat_bits (lane_stat[4*g +: 3]),
            .adj_nib   (lane_adj[4*g +: 4]),
            .cr_ok     (cr_vec[g]),
            .eq_ok     (eq_vec[g]),
            .swing     (sw_vec[g]),
            .emph      (pe_vec[g])
        );
    end

    logic [1:0] sw_max;
    logic [1:0] pe_max;

    always_comb begin
        sw_max = 2'd0;
        pe_max = 2'd0;
        for (int i = 0; i < LANES; i++) begin
            if (sw_vec[i] > sw_max) sw_max = sw_vec[i];
            if (pe_vec[i] > pe_max) pe_max = pe_vec[i];
        end
        cr_all = &cr_vec;
        eq_all = align_ok && (&eq_vec);
        level  = {2'b00, (pe_max == 2'd3), pe_max, (sw_max == 2'd3), sw_max};
    end

endmodule

// File: rtl/lt_seq.sv
module lt_seq #(
    parameter int LANES      = 4,
    parameter int CYC_PER_US = 100,
    parameter int TMR_W      = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  sink_rev,
    input  logic        spread_cap,
    input  logic        tps3_ok,
    input  logic [2:0]  lane_cnt,
    input  logic [7:0]  rate_code,
    input  logic [7:0]  rd_interval,
    output logic        reg_req,
    output logic        reg_rd,
    output logic [15:0] reg_addr,
    output logic [7:0]  reg_wdata,
    output logic [2:0]  reg_len,
    input  logic        reg_ack,
    input  logic        reg_err,
    input  logic [47:0] reg_rdata,
    output logic        drv_req,
    output logic [1:0]  drv_pattern,
    output logic [7:0]  drv_level,
    input  logic        drv_ack,
    output logic        busy,
    output logic        done,
    output logic        pass
);
    import lt_pkg::*;

    localparam int NIB_W = 4 * LANES;
    localparam logic [TMR_W-1:0] SETTLE_CYC = TMR_W'(400 * CYC_PER_US);
    localparam logic [TMR_W-1:0] CR_POLL    = TMR_W'(100 * CYC_PER_US);
    localparam logic [TMR_W-1:0] EQ_POLL    = TMR_W'(400 * CYC_PER_US);
    localparam logic [TMR_W-1:0] MS4_CYC    = TMR_W'(4000 * CYC_PER_US);

    typedef struct packed {
        lt_state_e        st;
        logic             eq;
        logic             first;
        logic [2:0]       tries;
        logic [1:0]       lastv;
        logic             lastv_vld;
        logic [1:0]       pattern;
        logic [7:0]       level;
        logic [TMR_W-1:0] cnt;
        logic [NIB_W-1:0] lstat;
        logic             align;
        logic [NIB_W-1:0] ladj;
        logic             pass;
        logic             done;
    } seq_t;

    seq_t q, d;

    logic       cr_all, eq_all;
    logic [7:0] new_level;

    lt_status_eval #(.LANES(LANES), .LCNT_W(3)) u_eval (
        .lane_cnt  (lane_cnt),
        .lane_stat (q.lstat),
        .lane_adj  (q.ladj),
        .align_ok  (q.align),
        .cr_all    (cr_all),
        .eq_all    (eq_all),
        .level     (new_level)
    );

    logic [TMR_W-1:0] poll_cyc;
    always_comb begin
        if (rd_interval == 8'd0) poll_cyc = q.eq ? EQ_POLL : CR_POLL;
        else                     poll_cyc = TMR_W'(rd_interval) * MS4_CYC;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: if (start) begin
                d.pass = 1'b0;
                d.eq   = 1'b0;
                d.st   = (sink_rev >= REV_NEW) ? S_POWER : S_SPREAD;
            end
            S_POWER:  if (reg_ack) d.st = S_SPREAD;
            S_SPREAD: if (reg_ack) d.st = S_LANES;
            S_LANES:  if (reg_ack) d.st = S_RATE;
            S_RATE:   if (reg_ack) d.st = S_PAT_OFF;
            S_PAT_OFF: if (reg_ack) begin
                d.st        = S_PAT_SRC;
                d.pattern   = 2'd1;
                d.level     = 8'h00;
                d.first     = 1'b1;
                d.tries     = 3'd0;
                d.lastv_vld = 1'b0;
            end
            S_PAT_SRC: if (drv_ack) d.st = S_PAT_SNK;
            S_PAT_SNK: if (reg_ack) begin
                if (q.eq) begin
                    d.st  = S_WAIT;
                    d.cnt = poll_cyc - 1'b1;
                end else begin
                    d.st = S_LVL_SNK;
                end
            end
            S_LVL_DRV: if (drv_ack) d.st = S_LVL_SNK;
            S_LVL_SNK: if (reg_ack) begin
                if (q.first) begin
                    d.first = 1'b0;
                    d.st    = S_SETTLE;
                    d.cnt   = SETTLE_CYC - 1'b1;
                end else begin
                    d.st  = S_WAIT;
                    d.cnt = poll_cyc - 1'b1;
                end
            end
            S_SETTLE: begin
                if (q.cnt == '0) begin
                    d.st  = S_WAIT;
                    d.cnt = poll_cyc - 1'b1;
                end else d.cnt = q.cnt - 1'b1;
            end
            S_WAIT: begin
                if (q.cnt == '0) d.st = S_READ;
                else             d.cnt = q.cnt - 1'b1;
            end
            S_READ: if (reg_ack) begin
                d.lstat = reg_rdata[NIB_W-1:0];
                d.align = reg_rdata[16];
                d.ladj  = reg_rdata[32 +: NIB_W];
                if (reg_err) begin
                    d.pass = 1'b0;
                    d.st   = S_FIN_WAIT;
                    d.cnt  = SETTLE_CYC - 1'b1;
                end else d.st = S_EVAL;
            end
            S_EVAL: begin
                d.st  = S_FIN_WAIT;
                d.cnt = SETTLE_CYC - 1'b1;
                if (!q.eq) begin
                    if (cr_all) begin
                        d.eq      = 1'b1;
                        d.tries   = 3'd0;
                        d.pattern = tps3_ok ? 2'd3 : 2'd2;
                        d.st      = S_PAT_SRC;
                    end else if (!q.level[2]) begin
                        d.lastv     = q.level[1:0];
                        d.lastv_vld = 1'b1;
                        if (q.lastv_vld && (q.level[1:0] == q.lastv)) begin
                            d.tries = q.tries + 3'd1;
                        end else begin
                            d.tries = 3'd0;
                        end
                        if (!(q.lastv_vld && (q.level[1:0] == q.lastv) &&
                              (q.tries == 3'(CR_REPEAT_MAX - 1)))) begin
                            d.level = new_level;
                            d.st    = S_LVL_DRV;
                        end
                    end
                end else begin
                    if (eq_all) begin
                        d.pass = 1'b1;
                    end else if (q.tries <= 3'(EQ_ADJUST_MAX)) begin
                        d.level = new_level;
                        d.tries = q.tries + 3'd1;
                        d.st    = S_LVL_DRV;
                    end
                end
            end
            S_FIN_WAIT: begin
                if (q.cnt == '0) d.st = S_FIN_SNK;
                else             d.cnt = q.cnt - 1'b1;
            end
            S_FIN_SNK: if (reg_ack) begin
                d.st      = S_FIN_SRC;
                d.pattern = 2'd0;
            end
            S_FIN_SRC: if (drv_ack) begin
                d.st   = S_IDLE;
                d.done = 1'b1;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_req   = 1'b1;
        reg_rd    = 1'b0;
        reg_addr  = ADR_PATTERN;
        reg_wdata = 8'h00;
        reg_len   = 3'd1;
        drv_req   = 1'b0;
        unique case (q.st)
            S_POWER:  begin reg_addr = ADR_POWER;  reg_wdata = POWER_D0; end
            S_SPREAD: begin
                reg_addr  = ADR_SPREAD;
                reg_wdata = spread_cap ? SPREAD_HALF : 8'h00;
            end
            S_LANES: begin
                reg_addr  = ADR_LANES;
                reg_wdata = {(sink_rev >= REV_NEW), 4'b0000, lane_cnt};
            end
            S_RATE:    begin reg_addr = ADR_RATE; reg_wdata = rate_code; end
            S_PAT_OFF, S_FIN_SNK: reg_wdata = 8'h00;
            S_PAT_SNK: reg_wdata = {6'b0, q.pattern};
            S_LVL_SNK: begin
                reg_addr  = ADR_LANE_SET;
                reg_wdata = q.level;
                reg_len   = lane_cnt;
            end
            S_READ: begin
                reg_rd   = 1'b1;
                reg_addr = ADR_STATUS;
                reg_len  = STATUS_BYTES;
            end
            S_PAT_SRC, S_LVL_DRV, S_FIN_SRC: begin
                reg_req = 1'b0;
                drv_req = 1'b1;
            end
            default: reg_req = 1'b0;
        endcase
        drv_pattern = q.pattern;
        drv_level   = q.level;
        busy        = (q.st != S_IDLE);
        done        = q.done;
        pass        = q.pass;
    end

endmodule

// File: rtl/lt_seq_chk.sv
module lt_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  sink_rev,
    input logic        reg_req,
    input logic        reg_rd,
    input logic [15:0] reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        reg_ack,
    input logic        drv_req,
    input logic [7:0]  drv_level,
    input logic        busy,
    input logic        done
);

    p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_wdata)));

    p_one_port_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && drv_req));

    p_power_rev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_rd && reg_addr == 16'h0600) |-> (sink_rev >= 8'h11));

    p_framing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_rd && reg_addr == 16'h0101) |-> (reg_wdata[7] == (sink_rev >= 8'h11)));

    p_max_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_req |-> ((drv_level[2] == (drv_level[1:0] == 2'd3)) &&
                     (drv_level[5] == (drv_level[4:3] == 2'd3))));

    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_req && !drv_req));

endmodule

bind lt_seq lt_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sink_rev  (sink_rev),
    .reg_req   (reg_req),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ack   (reg_ack),
    .drv_req   (drv_req),
    .drv_level (drv_level),
    .busy      (busy),
    .done      (done)
);

// File: tb/lt_seq_tb.sv
module lt_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CPU = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  sink_rev = 8'h12;
    logic        spread_cap = 1'b0;
    logic        tps3_ok = 1'b0;
    logic [2:0]  lane_cnt = 3'd1;
    logic [7:0]  rate_code = 8'h0A;
    logic [7:0]  rd_interval = 8'd0;
    logic        reg_req, reg_rd;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic [2:0]  reg_len;
    logic        reg_ack = 1'b0;
    logic        reg_err = 1'b0;
    logic [47:0] reg_rdata = '0;
    logic        drv_req;
    logic [1:0]  drv_pattern;
    logic [7:0]  drv_level;
    logic        drv_ack = 1'b0;
    logic        busy, done, pass;

    lt_seq #(.LANES(4), .CYC_PER_US(CPU), .TMR_W(32)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // transaction log: kind 0 = write, 1 = read, 2 = drive
    int          n_log;
    int          lk [64];
    logic [15:0] la [64];
    logic [7:0]  ld [64];
    int          ll [64];
    int          lt [64];
    int          n_exp;
    int          ek [64];
    logic [15:0] ea [64];
    logic [7:0]  ed [64];
    int          el [64];

    logic [47:0] stat_mem [16];
    int          rd_idx;
    int          err_idx;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    initial begin : reg_responder
        forever begin
            @(negedge clk);
            if (reg_ack) begin
                reg_ack = 1'b0;
                reg_err = 1'b0;
            end else if (reg_req && n_log < 64) begin
                lk[n_log] = reg_rd ? 1 : 0;
                la[n_log] = reg_addr;
                ld[n_log] = reg_rd ? 8'h00 : reg_wdata;
                ll[n_log] = int'(reg_len);
                lt[n_log] = cyc;
                n_log++;
                if (reg_rd) begin
                    reg_rdata = stat_mem[(rd_idx > 15) ? 15 : rd_idx];
                    reg_err   = (rd_idx == err_idx);
                    rd_idx++;
                end
                reg_ack = 1'b1;
            end
        end
    end

    initial begin : drv_responder
        forever begin
            @(negedge clk);
            if (drv_ack) drv_ack = 1'b0;
            else if (drv_req && n_log < 64) begin
                lk[n_log] = 2;
                la[n_log] = {14'b0, drv_pattern};
                ld[n_log] = drv_level;
                ll[n_log] = 0;
                lt[n_log] = cyc;
                n_log++;
                drv_ack = 1'b1;
            end
        end
    end

    task automatic ew(input logic [15:0] a, input logic [7:0] dv, input int len);
        ek[n_exp] = 0; ea[n_exp] = a; ed[n_exp] = dv; el[n_exp] = len; n_exp++;
    endtask
    task automatic er();
        ek[n_exp] = 1; ea[n_exp] = 16'h0202; ed[n_exp] = 8'h00; el[n_exp] = 6; n_exp++;
    endtask
    task automatic edr(input logic [1:0] p, input logic [7:0] lv);
        ek[n_exp] = 2; ea[n_exp] = {14'b0, p}; ed[n_exp] = lv; el[n_exp] = 0; n_exp++;
    endtask

    // R2, R3, R4: start-up writes and clock recovery entry
    task automatic exp_init();
        if (sink_rev >= 8'h11) ew(16'h0600, 8'h01, 1);
        ew(16'h0107, spread_cap ? 8'h10 : 8'h00, 1);
        ew(16'h0101, {(sink_rev >= 8'h11), 4'b0, lane_cnt}, 1);
        ew(16'h0100, rate_code, 1);
        ew(16'h0102, 8'h00, 1);
        edr(2'd1, 8'h00);
        ew(16'h0102, 8'h01, 1);
        ew(16'h0103, 8'h00, int'(lane_cnt));
    endtask

    task automatic exp_finish(input logic [7:0] lv);
        ew(16'h0102, 8'h00, 1);
        edr(2'd0, lv);
    endtask

    task automatic prep();
        n_log = 0; n_exp = 0; rd_idx = 0; err_idx = -1;
        for (int i = 0; i < 16; i++) stat_mem[i] = '0;
    endtask

    task automatic run(input string req, input int exp_pass);
        int t;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check({req, " done"}, int'(done), 1);
        check({req, " pass"}, int'(pass), exp_pass);
        check({req, " log length"}, n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            check({req, " kind"}, lk[i], ek[i]);
            check({req, " addr"}, int'(la[i]), int'(ea[i]));
            check({req, " data"}, int'(ld[i]), int'(ed[i]));
            check({req, " len"},  ll[i], el[i]);
        end
        @(negedge clk);
        check("R12 done one cycle", int'(done), 0);
        check("R1 idle after run", int'(busy), 0);
    endtask

    function automatic int find(input int kind, input logic [15:0] a, input int from);
        for (int i = from; i < n_log; i++)
            if (lk[i] == kind && la[i] == a) return i;
        return -1;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int i0, i1;
        n_log = 0;
        prep();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 pass", int'(pass), 0);
        check("R1 reg_req", int'(reg_req), 0);
        check("R1 drv_req", int'(drv_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", int'(busy | reg_req | drv_req), 0);

        // T1 new sink, spread, 4 lanes, pattern 3; immediate pass (R2 R3 R4 R6 R9 R10 R12)
        prep();
        sink_rev = 8'h12; spread_cap = 1; lane_cnt = 3'd4; tps3_ok = 1; rate_code = 8'h14;
        stat_mem[0] = {16'h0, 8'h0, 8'h00, 8'h11, 8'h11};
        stat_mem[1] = {16'h0, 8'h0, 8'h01, 8'h77, 8'h77};
        exp_init(); er(); edr(2'd3, 8'h00); ew(16'h0102, 8'h03, 1); er(); exp_finish(8'h00);
        run("R10 T1", 1);
        i0 = find(0, 16'h0103, 0);
        i1 = find(1, 16'h0202, 0);
        if (i0 >= 0 && i1 >= 0) check("R4 settle plus poll gap", lt[i1] - lt[i0], 501 * CPU);
        i0 = find(0, 16'h0102, i1);
        i1 = find(1, 16'h0202, i1 + 1);
        if (i0 >= 0 && i1 >= 0) check("R5 eq poll gap", lt[i1] - lt[i0], 401 * CPU);
        i0 = find(0, 16'h0102, i1);
        if (i0 >= 0 && i1 >= 0) check("R12 finish wait", lt[i0] - lt[i1], 402 * CPU);

        // T2 old sink, 2 lanes, lanes 2/3 not locked but inactive (R2 R3 R6 R9)
        prep();
        sink_rev = 8'h10; spread_cap = 0; lane_cnt = 3'd2; tps3_ok = 0; rate_code = 8'h0A;
        stat_mem[0] = {16'h0, 8'h0, 8'h00, 8'h00, 8'h11};
        stat_mem[1] = {16'h0, 8'h0, 8'h01, 8'h00, 8'h77};
        exp_init(); er(); edr(2'd2, 8'h00); ew(16'h0102, 8'h02, 1); er(); exp_finish(8'h00);
        run("R6 T2", 1);

        // T3 merge over 2 lanes, inactive lane 2 request ignored (R7)
        prep();
        sink_rev = 8'h11; lane_cnt = 3'd2;
        stat_mem[0] = {8'h0F, 8'h29, 8'h0, 8'h00, 8'h00, 8'h00};
        stat_mem[1] = {8'h0F, 8'h29, 8'h0, 8'h00, 8'h00, 8'h11};
        stat_mem[2] = {16'h0, 8'h0, 8'h01, 8'h00, 8'h77};
        exp_init(); er(); edr(2'd1, 8'h12); ew(16'h0103, 8'h12, 2); er();
        edr(2'd2, 8'h12); ew(16'h0102, 8'h02, 1); er(); exp_finish(8'h12);
        run("R7 T3", 1);
        i0 = find(0, 16'h0103, 8);
        i1 = find(1, 16'h0202, i0 > 0 ? i0 : 0);
        if (i0 >= 0 && i1 >= 0) check("R5 cr poll gap", lt[i1] - lt[i0], 101 * CPU);

        // T4 same status, 4 lanes: max flags set, then R8 max-swing stop on next poll
        prep();
        lane_cnt = 3'd4;
        stat_mem[0] = {8'h0F, 8'h29, 8'h0, 8'h00, 8'h00, 8'h00};
        exp_init(); er(); edr(2'd1, 8'h3F); ew(16'h0103, 8'h3F, 4); er(); exp_finish(8'h3F);
        run("R8 T4 max swing", 0);

        // T5 repeated voltage: five repeats stop clock recovery (R8)
        prep();
        lane_cnt = 3'd1;
        exp_init();
        for (int k = 0; k < 5; k++) begin er(); edr(2'd1, 8'h00); ew(16'h0103, 8'h00, 1); end
        er(); exp_finish(8'h00);
        run("R8 T5 repeats", 0);

        // T6 equalisation never aligns: fails on seventh poll (R11)
        prep();
        tps3_ok = 1;
        for (int k = 0; k < 16; k++) stat_mem[k] = {16'h0, 8'h0, 8'h00, 8'h00, 8'h07};
        exp_init(); er(); edr(2'd3, 8'h00); ew(16'h0102, 8'h03, 1);
        for (int k = 0; k < 6; k++) begin er(); edr(2'd3, 8'h00); ew(16'h0103, 8'h00, 1); end
        er(); exp_finish(8'h00);
        run("R11 T6", 0);

        // T7 status read error ends training (R13)
        prep();
        err_idx = 0;
        exp_init(); er(); exp_finish(8'h00);
        run("R13 T7", 0);
        i0 = find(1, 16'h0202, 0);
        i1 = find(0, 16'h0102, i0 > 0 ? i0 : 0);
        if (i0 >= 0 && i1 >= 0) check("R13 direct finish", lt[i1] - lt[i0], 401 * CPU);

        // T8 nonzero interval field (R5)
        prep();
        rd_interval = 8'd1;
        stat_mem[0] = {16'h0, 8'h0, 8'h00, 8'h00, 8'h01};
        stat_mem[1] = {16'h0, 8'h0, 8'h01, 8'h00, 8'h07};
        exp_init(); er(); edr(2'd3, 8'h00); ew(16'h0102, 8'h03, 1); er(); exp_finish(8'h00);
        run("R5 T8", 1);
        i0 = find(0, 16'h0103, 0);
        i1 = find(1, 16'h0202, 0);
        if (i0 >= 0 && i1 >= 0) check("R5 interval gap", lt[i1] - lt[i0], (400 + 4000) * CPU + 1);
        rd_interval = 8'd0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule